// File: doc/BRIEF.md
# Configurable External Interrupt Controller

This block watches a parameterised set of external interrupt lines, up to 32 of them. Each line has its own sense setting and can be one of rising edge, falling edge, active-high level or active-low level. Every line first passes through a two-flop synchroniser. An event that is detected sets a sticky pending bit. Software reaches the block over a simple word-wide register bus. It unmasks lines through a write-one-to-set register and masks them through a write-one-to-clear register. It acknowledges pending bits by writing ones to an acknowledge register.

The block drives two outputs. The combined output `irq_out` is high whenever some pending bit has its mask bit set. One parameter-selected line can also raise `nmi_out`. That output depends only on a separate enable bit and ignores the mask. Configuration bits for lines that are not built read back as zero. Software can therefore write all ones to the sense-mode register, read it back, and find how many lines exist.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset every register reads zero, so all lines sense falling edges, all are masked, nothing is pending and `irq_out` and `nmi_out` are low.
- R2: Writing to byte offset 0x00 sets the mask bits where the write data has ones. Writing to 0x04 clears the mask bits where the data has ones. Zero bits leave the mask alone. The mask reads back at 0x08.
- R3: Writing to offset 0x10 clears each pending bit where the data has a one. Zero bits leave pending bits unchanged. Pending bits read at 0x0C, with bit n for line n.
- R4: A line whose mode bit (offset 0x14) is 0 senses edges. Its edge bit (offset 0x18) set to 1 selects rising edges and 0 selects falling edges. The pending bit is visible at the third rising clock edge after the input changes.
- R5: A line whose mode bit is 1 senses levels. Its level bit (offset 0x1C) set to 1 means active high and 0 means active low. The pending bit is set on every cycle the synchronised input sits at the active level, so an acknowledge does not clear it while the input stays active. Once set, it remains set after the input leaves the active level.
- R6: When an event and an acknowledge hit the same pending bit in the same cycle, the bit ends up set.
- R7: Bits above the number of built lines cannot be written and read as zero in the mask, mode, edge and level registers. Writing all ones to the mode register reads back as 2^NUM_LINES-1.
- R8: `irq_out` is high exactly when some pending bit has its mask bit set.
- R9: Bit 0 at offset 0x24 enables the non-maskable path. While it is 1, `nmi_out` follows the pending bit of line NMI_LINE regardless of the mask. Writing 0 drops `nmi_out`.
- R10: A read presents its data on `bus_rdata` after the next rising clock edge and holds it until the next read. Offsets that no register uses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_in | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined maskable interrupt |
| nmi_out | output | 1 | Non-maskable interrupt for line NMI_LINE |

## Verification
The assertions check several properties on every cycle.
- A set or clear write to the mask takes effect at once, and no other write moves the mask.
- An acknowledge removes only bits that have no fresh event.
- An event always lands in the pending register, even against an acknowledge.
- Without events or acknowledges the pending register stays stable.
- An edge-sensed line never reports events in two cycles in a row.

The bench scenarios cover the rest. They show the sense selection for each of the four modes and the synchroniser latency. They also cover re-latching of a level that is still active, the same-cycle collision of an event with an acknowledge, read-back of lines that are not built, and the non-maskable path bypassing the mask.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   localparam int unsigned WORD_W = 32;
   // software-visible byte offsets
   localparam logic [7:0] OFS_EN_SET = 8'h00;
   localparam logic [7:0] OFS_EN_CLR = 8'h04;
   localparam logic [7:0] OFS_MASK   = 8'h08;
   localparam logic [7:0] OFS_PEND   = 8'h0C;
   localparam logic [7:0] OFS_ACK    = 8'h10;
   localparam logic [7:0] OFS_MODE   = 8'h14;
   localparam logic [7:0] OFS_EDGE   = 8'h18;
   localparam logic [7:0] OFS_LVL    = 8'h1C;
   localparam logic [7:0] OFS_NMI    = 8'h24;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("xirq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= din;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[LAST];
endmodule

// File: rtl/xirq_sense.sv
module xirq_sense #(
   parameter int unsigned NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_s,
   input  logic [NUM_LINES-1:0] mode,
   input  logic [NUM_LINES-1:0] edge_pol,
   input  logic [NUM_LINES-1:0] level_pol,
   output logic [NUM_LINES-1:0] evt
);
   logic [NUM_LINES-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= line_s;
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign evt[i] = mode[i] ? (line_s[i] == level_pol[i])
                              : ((line_s[i] != prev[i]) && (line_s[i] == edge_pol[i]));
   end

   // R4: an edge-sensed line cannot report in two consecutive cycles
   assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt & ~mode & $past(evt & ~mode)) == '0));
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NMI_LINE  = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [WORD_W-1:0]    bus_wdata,
   output logic [WORD_W-1:0]    bus_rdata,
   input  logic [NUM_LINES-1:0] evt,
   output logic [NUM_LINES-1:0] mode,
   output logic [NUM_LINES-1:0] edge_pol,
   output logic [NUM_LINES-1:0] level_pol,
   output logic                 irq_out,
   output logic                 nmi_out
);
   logic [NUM_LINES-1:0] mask, pend, wbits, ack_bits;
   logic                 nmi_en;
   logic                 unused_wdata;

   function automatic logic hit(input logic [7:0] ofs);
      return bus_addr == ADDR_W'(ofs);
   endfunction

   assign wbits        = bus_wdata[NUM_LINES-1:0];
   assign unused_wdata = ^bus_wdata;
   assign ack_bits     = (bus_wr && hit(OFS_ACK)) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask      <= '0;
         pend      <= '0;
         mode      <= '0;
         edge_pol  <= '0;
         level_pol <= '0;
         nmi_en    <= 1'b0;
      end else begin
         pend <= (pend & ~ack_bits) | evt;
         if (bus_wr) begin
            if (hit(OFS_EN_SET)) mask      <= mask | wbits;
            if (hit(OFS_EN_CLR)) mask      <= mask & ~wbits;
            if (hit(OFS_MODE))   mode      <= wbits;
            if (hit(OFS_EDGE))   edge_pol  <= wbits;
            if (hit(OFS_LVL))    level_pol <= wbits;
            if (hit(OFS_NMI))    nmi_en    <= bus_wdata[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         if      (hit(OFS_MASK)) bus_rdata <= WORD_W'(mask);
         else if (hit(OFS_PEND)) bus_rdata <= WORD_W'(pend);
         else if (hit(OFS_MODE)) bus_rdata <= WORD_W'(mode);
         else if (hit(OFS_EDGE)) bus_rdata <= WORD_W'(edge_pol);
         else if (hit(OFS_LVL))  bus_rdata <= WORD_W'(level_pol);
         else if (hit(OFS_NMI))  bus_rdata <= WORD_W'(nmi_en);
         else                    bus_rdata <= '0;
      end
   end

   assign irq_out = |(pend & mask);
   assign nmi_out = nmi_en & pend[NMI_LINE];

   assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit(OFS_EN_SET)) |=> ((mask & $past(wbits)) == $past(wbits)));
   assert_mask_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit(OFS_EN_CLR)) |=> ((mask & $past(wbits)) == '0));
   assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && (hit(OFS_EN_SET) || hit(OFS_EN_CLR))) |=> $stable(mask));
   assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit(OFS_ACK)) |=> ((pend & $past(wbits & ~evt)) == '0));
   assert_pend_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_bits == '0 && evt == '0) |=> $stable(pend));
   assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & $past(evt)) == $past(evt)));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
   import xirq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned NMI_LINE    = 0,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] ext_in,
   input  logic                 bus_rd,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 irq_out,
   output logic                 nmi_out
);
   if (NUM_LINES < 1 || NUM_LINES > WORD_W) begin : g_bad_lines
      $error("xirq_ctrl: NUM_LINES must be 1..32");
   end
   if (NMI_LINE >= NUM_LINES) begin : g_bad_nmi
      $error("xirq_ctrl: NMI_LINE must name a built line");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("xirq_ctrl: ADDR_W too small for register map");
   end

   logic [NUM_LINES-1:0] line_s, evt, mode, edge_pol, level_pol;

   xirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_in), .dout(line_s));

   xirq_sense #(.NUM_LINES(NUM_LINES)) u_sense (
      .clk(clk), .rst_n(rst_n), .line_s(line_s), .mode(mode),
      .edge_pol(edge_pol), .level_pol(level_pol), .evt(evt));

   xirq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .NMI_LINE(NMI_LINE)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt(evt), .mode(mode), .edge_pol(edge_pol), .level_pol(level_pol),
      .irq_out(irq_out), .nmi_out(nmi_out));
endmodule

// File: tb/sim_xirq_ctrl.sv
module sim_xirq_ctrl;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] ext_in = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out, nmi_out;
   int          n_tests = 0, n_fail = 0;
   logic [31:0] r;

   always #10 clk = ~clk;

   xirq_ctrl #(.NUM_LINES(N)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out), .nmi_out(nmi_out));

   // {mode, edge_bit, level_bit, input_before, input_after, expected_pending}
   localparam logic [5:0] VEC [10] = '{
      6'b0_1_0_0_1_1, 6'b0_1_0_1_0_0, 6'b0_0_0_1_0_1, 6'b0_0_0_0_1_0,
      6'b0_1_0_0_0_0, 6'b1_0_1_0_1_1, 6'b1_0_1_0_0_0, 6'b1_0_0_1_1_0,
      6'b1_0_0_0_1_1, 6'b1_0_1_1_0_1};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 irq_out", {31'b0, irq_out}, 32'h0);
      check("R1 nmi_out", {31'b0, nmi_out}, 32'h0);
      rd(8'h08, r); check("R1 mask", r, 32'h0);
      rd(8'h0C, r); check("R1 pending", r, 32'h0);
      rd(8'h14, r); check("R1 mode", r, 32'h0);
      rd(8'h18, r); check("R1 edge", r, 32'h0);
      rd(8'h1C, r); check("R1 level", r, 32'h0);
      rd(8'h24, r); check("R1 nmi ctl", r, 32'h0);
      // R10 unmapped offsets and hold
      rd(8'h20, r); check("R10 unmapped 0x20", r, 32'h0);
      rd(8'h2C, r); check("R10 unmapped 0x2C", r, 32'h0);
      // R2 mask set/clear
      wr(8'h00, 32'h05); rd(8'h08, r); check("R2 set 05", r, 32'h05);
      wr(8'h00, 32'h02); rd(8'h08, r); check("R2 set 02", r, 32'h07);
      wr(8'h04, 32'h04); rd(8'h08, r); check("R2 clr 04", r, 32'h03);
      wr(8'h04, 32'h00); rd(8'h08, r); check("R2 clr zero", r, 32'h03);
      @(negedge clk); check("R10 rdata held", bus_rdata, 32'h03);
      wr(8'h04, 32'hFF);
      // R7 unimplemented bits
      wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, r); check("R7 mode probe", r, 32'h0000_00FF);
      wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, r); check("R7 edge", r, 32'h0000_00FF);
      wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, r); check("R7 level", r, 32'h0000_00FF);
      wr(8'h00, 32'hFFFF_FFFF); rd(8'h08, r); check("R7 mask", r, 32'h0000_00FF);
      wr(8'h04, 32'hFF); wr(8'h14, 32'h0); wr(8'h18, 32'h0); wr(8'h1C, 32'h0);
      settle(); wr(8'h10, 32'hFF);
      rd(8'h0C, r); check("R3 cleared all", r, 32'h0);
      // R4 / R5 sense table on line 0
      for (int v = 0; v < 10; v++) begin
         wr(8'h14, {31'b0, VEC[v][5]});
         wr(8'h18, {31'b0, VEC[v][4]});
         wr(8'h1C, {31'b0, VEC[v][3]});
         @(negedge clk); ext_in[0] = VEC[v][2];
         settle();
         wr(8'h10, 32'h01);
         ext_in[0] = VEC[v][1];
         settle();
         rd(8'h0C, r);
         check(VEC[v][5] ? "R5 level sense" : "R4 edge sense", r & 32'h1, {31'b0, VEC[v][0]});
      end
      // R6 event and acknowledge in same cycle, line 1 rising edge
      wr(8'h14, 32'h0); wr(8'h1C, 32'h0); wr(8'h18, 32'h02);
      settle(); wr(8'h10, 32'hFF);
      @(negedge clk); ext_in[1] = 1'b1;
      @(negedge clk);
      wr(8'h10, 32'h02);
      rd(8'h0C, r); check("R6 event wins", r & 32'h2, 32'h2);
      // R4 latency: not visible before the third edge
      @(negedge clk); ext_in[2] = 1'b1; wr(8'h18, 32'h06);
      rd(8'h0C, r); check("R4 latency", r & 32'h4, 32'h4);
      // R3 acknowledge with zero bits leaves others
      wr(8'h10, 32'h01); rd(8'h0C, r); check("R3 zero bit keeps", r & 32'h6, 32'h6);
      wr(8'h10, 32'h06); rd(8'h0C, r); check("R3 ack clears", r, 32'h0);
      // R8 combined output
      @(negedge clk); ext_in[1] = 1'b0; settle(); ext_in[1] = 1'b1; settle();
      check("R8 masked pending", {31'b0, irq_out}, 32'h0);
      wr(8'h00, 32'h02); check("R8 unmasked", {31'b0, irq_out}, 32'h1);
      wr(8'h04, 32'h02); check("R8 masked again", {31'b0, irq_out}, 32'h0);
      wr(8'h00, 32'h02); wr(8'h10, 32'h02); check("R8 acked", {31'b0, irq_out}, 32'h0);
      wr(8'h04, 32'hFF);
      // R9 non-maskable path on line 0
      wr(8'h18, 32'h03);
      @(negedge clk); ext_in[0] = 1'b1; settle();
      check("R9 nmi disabled", {31'b0, nmi_out}, 32'h0);
      wr(8'h24, 32'h1);
      check("R9 nmi enabled", {31'b0, nmi_out}, 32'h1);
      check("R9 irq masked", {31'b0, irq_out}, 32'h0);
      rd(8'h24, r); check("R9 nmi ctl read", r, 32'h1);
      wr(8'h24, 32'h0);
      check("R9 nmi off", {31'b0, nmi_out}, 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule